// File: doc/BRIEF.md
# Attribute Register Port

This block holds the colour-attribute register set of a display adapter behind one byte-wide write port that carries both register numbers and register contents. A one-bit phase flip-flop steers each write: in the index phase the byte selects a register and sets the screen-enable flag. In the data phase the byte goes into the selected register. Every write flips the phase.

A strobe on the status port forces the flip-flop back to the index phase. Host software can therefore always resynchronise before it starts a sequence. Two more read strobes return the current index byte or the contents of the selected register; neither of them changes the phase. The block stores 21 registers: sixteen palette slots, mode control, overscan colour, two further control registers and a 4-bit colour select. The screen-enable flag is driven out so the display path can blank the picture.

Top module: `attr_port`

## Requirements
- R1: While `rst` is high at a clock edge, every register, the index and the screen flag are cleared and the phase flip-flop returns to the index phase. A data-port read then returns 0x00 and an index-port read returns 0x00.
- R2: A cycle with `bus_rd_status` high and `bus_wr` low leaves the phase flip-flop in the index phase, so the next write loads the index.
- R3: A write in the index phase stores written bits 4:0 as the register number and bit 5 as the screen flag. Writing 0x20 drives `screen_on` to 1 after the edge; writing 0x00 drives it to 0. An index-port read returns {2'b00, flag, number}.
- R4: A write in the data phase stores the byte in the selected register and returns the flip-flop to the index phase, so successive writes alternate index, data, index, data.
- R5: A data-port read returns the register selected by the current index and does not change the phase.
- R6: Writes while the index is above 0x14 change no register. Data-port reads at such an index return 0x00.
- R7: Register 0x14 (colour select) keeps only its low 4 bits; its upper 4 bits read as zero.
- R8: Register 0x10 (mode control) keeps all eight bits, including bit 7 (paging select) and bit 3 (blink/intensity). A read-modify-write of bit 3 leaves the other bits as they were. Registers 0x00 to 0x13 keep all eight bits.
- R9: A status-port read returns bit 0 = 1 when the flip-flop is in the data phase before the read. Bits 7:1 are zero.
- R10: A write in the same cycle as a status read is taken as an index write, and the flip-flop ends in the data phase.
- R11: A data write changes neither the index nor `screen_on`.
- R12: `bus_rdata` is 0x00 when no read strobe is high. When several read strobes are high together, status takes precedence over data, and data over index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the shared index/data port |
| bus_wdata | input | 8 | Write byte |
| bus_rd_status | input | 1 | Status read strobe; returns the phase and clears it to the index phase |
| bus_rd_index | input | 1 | Index read strobe |
| bus_rd_data | input | 1 | Selected-register read strobe |
| bus_rdata | output | 8 | Read byte, combinational from the strobes |
| screen_on | output | 1 | Screen-enable flag from the index register |

## Verification
The assertions check the following on every cycle:
- the phase rules: a status read clears the phase, a status read together with a write ends in the data phase, and a data write returns to the index phase;
- that a data read leaves the phase untouched;
- that a data write leaves `screen_on` untouched;
- the shape of the status byte and the idle read value;
- the blank state after reset.

Register contents need the bench's scenarios, which write and read back through the ports. These cover the dropped upper bits of colour select, the full-width mode-control read-modify-write, the ignored out-of-range indices, and the alternation of index and data writes across long sequences.

// File: rtl/attr_port_pkg.sv
package attr_port_pkg;

    localparam int DATA_W     = 8;
    localparam int IDX_W      = 5;
    localparam int SCREEN_BIT = IDX_W;

    typedef enum logic {
        PH_INDEX = 1'b0,
        PH_DATA  = 1'b1
    } phase_e;

    typedef struct packed {
        logic             screen;
        logic [IDX_W-1:0] sel;
    } index_t;

    function automatic logic [DATA_W-1:0] index_byte(input index_t ix);
        return DATA_W'({ix.screen, ix.sel});
    endfunction

endpackage

// File: rtl/attr_phase.sv
module attr_phase
    import attr_port_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   status_rd,
    input  logic   wr,
    output phase_e phase
);
    phase_e phase_nx;

    always_comb begin
        phase_nx = phase;
        if (status_rd)
            phase_nx = wr ? PH_DATA : PH_INDEX;
        else if (wr)
            phase_nx = (phase == PH_INDEX) ? PH_DATA : PH_INDEX;
    end

    always_ff @(posedge clk) begin
        if (rst) phase <= PH_INDEX;
        else     phase <= phase_nx;
    end
endmodule

// File: rtl/attr_index.sv
module attr_index
    import attr_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    output index_t            ix
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ix <= '0;
        end else if (load) begin
            ix.sel    <= din[IDX_W-1:0];
            ix.screen <= din[SCREEN_BIT];
        end
    end
endmodule

// File: rtl/attr_regfile.sv
module attr_regfile
    import attr_port_pkg::*;
#(
    parameter int NUM_REGS = 21,
    parameter int CSEL_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int LAST = NUM_REGS - 1;

    logic [DATA_W-1:0] mem [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
        localparam logic [DATA_W-1:0] KEEP =
            (g == LAST) ? DATA_W'((1 << CSEL_W) - 1) : {DATA_W{1'b1}};
        always_ff @(posedge clk) begin
            if (rst)
                mem[g] <= '0;
            else if (we && sel == IDX_W'(g))
                mem[g] <= wdata & KEEP;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_REGS; i++)
            if (sel == IDX_W'(i)) rdata = mem[i];
    end
endmodule

// File: rtl/attr_port.sv
module attr_port
    import attr_port_pkg::*;
#(
    parameter int NUM_REGS = 21,
    parameter int CSEL_W   = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_wr,
    input  logic [7:0] bus_wdata,
    input  logic       bus_rd_status,
    input  logic       bus_rd_index,
    input  logic       bus_rd_data,
    output logic [7:0] bus_rdata,
    output logic       screen_on
);
    phase_e            phase;
    index_t            ix;
    logic              data_phase;
    logic              take_index;
    logic              take_data;
    logic [DATA_W-1:0] reg_q;

    assign data_phase = (phase == PH_DATA);
    assign take_index = bus_wr && (bus_rd_status || !data_phase);
    assign take_data  = bus_wr && !bus_rd_status && data_phase;
    assign screen_on  = ix.screen;

    attr_phase u_phase (
        .clk       (clk),
        .rst       (rst),
        .status_rd (bus_rd_status),
        .wr        (bus_wr),
        .phase     (phase)
    );

    attr_index u_index (
        .clk  (clk),
        .rst  (rst),
        .load (take_index),
        .din  (bus_wdata),
        .ix   (ix)
    );

    attr_regfile #(.NUM_REGS(NUM_REGS), .CSEL_W(CSEL_W)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (take_data),
        .sel   (ix.sel),
        .wdata (bus_wdata),
        .rdata (reg_q)
    );

    always_comb begin
        if (bus_rd_status)    bus_rdata = {7'b0, data_phase};
        else if (bus_rd_data) bus_rdata = reg_q;
        else if (bus_rd_index) bus_rdata = index_byte(ix);
        else                  bus_rdata = '0;
    end
endmodule

// File: rtl/attr_port_chk.sv
module attr_port_chk (
    input logic       clk,
    input logic       rst,
    input logic       bus_wr,
    input logic [7:0] bus_wdata,
    input logic       bus_rd_status,
    input logic       bus_rd_index,
    input logic       bus_rd_data,
    input logic [7:0] bus_rdata,
    input logic       screen_on,
    input logic       data_phase
);
    a_r1_reset_blank: assert property (@(posedge clk)
        rst |=> (!screen_on && !data_phase));

    a_r2_status_clears: assert property (@(posedge clk) disable iff (rst)
        (bus_rd_status && !bus_wr) |=> !data_phase);

    a_r10_status_with_write: assert property (@(posedge clk) disable iff (rst)
        (bus_rd_status && bus_wr) |=> data_phase);

    a_r4_data_then_index: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !bus_rd_status && data_phase) |=> !data_phase);

    a_r3_index_sets_screen: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && (bus_rd_status || !data_phase)) |=> (screen_on == $past(bus_wdata[5])));

    a_r11_data_keeps_screen: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !bus_rd_status && data_phase) |=> $stable(screen_on));

    a_r5_data_read_keeps_phase: assert property (@(posedge clk) disable iff (rst)
        (bus_rd_data && !bus_wr && !bus_rd_status) |=> $stable(data_phase));

    a_r9_status_shape: assert property (@(posedge clk) disable iff (rst)
        bus_rd_status |-> (bus_rdata[7:1] == 7'd0 && bus_rdata[0] == data_phase));

    a_r12_idle_zero: assert property (@(posedge clk) disable iff (rst)
        (!bus_rd_status && !bus_rd_index && !bus_rd_data) |-> (bus_rdata == 8'h00));
endmodule

bind attr_port attr_port_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .bus_wr        (bus_wr),
    .bus_wdata     (bus_wdata),
    .bus_rd_status (bus_rd_status),
    .bus_rd_index  (bus_rd_index),
    .bus_rd_data   (bus_rd_data),
    .bus_rdata     (bus_rdata),
    .screen_on     (screen_on),
    .data_phase    (data_phase)
);

// File: tb/attr_port_bench.sv
module attr_port_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic       bus_rd_status = 1'b0;
    logic       bus_rd_index = 1'b0;
    logic       bus_rd_data = 1'b0;
    logic [7:0] bus_rdata;
    logic       screen_on;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    attr_port u_attr_port (
        .clk           (clk),
        .rst           (rst),
        .bus_wr        (bus_wr),
        .bus_wdata     (bus_wdata),
        .bus_rd_status (bus_rd_status),
        .bus_rd_index  (bus_rd_index),
        .bus_rd_data   (bus_rd_data),
        .bus_rdata     (bus_rdata),
        .screen_on     (screen_on)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] v);
        @(negedge clk);
        bus_wr = 1'b1; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_status(output logic [7:0] v);
        @(negedge clk);
        bus_rd_status = 1'b1; #2 v = bus_rdata;
        @(negedge clk);
        bus_rd_status = 1'b0;
    endtask

    task automatic rd_index(output logic [7:0] v);
        @(negedge clk);
        bus_rd_index = 1'b1; #2 v = bus_rdata;
        @(negedge clk);
        bus_rd_index = 1'b0;
    endtask

    task automatic rd_data(output logic [7:0] v);
        @(negedge clk);
        bus_rd_data = 1'b1; #2 v = bus_rdata;
        @(negedge clk);
        bus_rd_data = 1'b0;
    endtask

    task automatic put_reg(input logic [7:0] idx, input logic [7:0] val);
        logic [7:0] s;
        rd_status(s);
        wr(idx);
        wr(val);
    endtask

    task automatic get_reg(input logic [7:0] idx, output logic [7:0] v);
        logic [7:0] s;
        rd_status(s);
        wr(idx);
        rd_data(v);
        rd_status(s);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        chk("R1 screen_on after reset", {7'b0, screen_on}, 8'h00);
        rd_index(v);  chk("R1 index after reset", v, 8'h00);
        rd_status(v); chk("R1 phase after reset", v, 8'h00);
        rd_data(v);   chk("R1 reg0 after reset", v, 8'h00);
    endtask

    task automatic t_index_data;
        logic [7:0] v;
        rd_status(v);
        wr(8'h25);
        chk("R3 screen on after 0x25", {7'b0, screen_on}, 8'h01);
        rd_index(v); chk("R3 index byte", v, 8'h25);
        wr(8'hAB);
        chk("R11 screen kept after data", {7'b0, screen_on}, 8'h01);
        rd_index(v); chk("R11 index kept after data", v, 8'h25);
        rd_status(v); chk("R4 index phase after data", v, 8'h00);
        wr(8'h05);
        chk("R3 screen off after 0x05", {7'b0, screen_on}, 8'h00);
        rd_data(v); chk("R5 data read reg5", v, 8'hAB);
    endtask

    task automatic t_alternate;
        logic [7:0] v;
        rd_status(v);
        wr(8'h21); wr(8'h11); wr(8'h22); wr(8'h33); wr(8'h23); wr(8'h44);
        get_reg(8'h01, v); chk("R4 alternation reg1", v, 8'h11);
        get_reg(8'h02, v); chk("R4 alternation reg2", v, 8'h33);
        get_reg(8'h03, v); chk("R4 alternation reg3", v, 8'h44);
    endtask

    task automatic t_status_mid;
        logic [7:0] v;
        rd_status(v);
        wr(8'h23);
        rd_status(v); chk("R9 status in data phase", v, 8'h01);
        rd_status(v); chk("R2 status cleared phase", v, 8'h00);
        wr(8'h24);
        rd_index(v); chk("R2 write after status loads index", v, 8'h24);
    endtask

    task automatic t_data_read_no_toggle;
        logic [7:0] v;
        rd_status(v);
        wr(8'h21);
        rd_data(v); chk("R5 data read reg1", v, 8'h11);
        rd_data(v); chk("R5 second data read reg1", v, 8'h11);
        rd_status(v); chk("R5 phase unchanged by data reads", v, 8'h01);
    endtask

    task automatic t_out_of_range;
        logic [7:0] v;
        put_reg(8'h35, 8'hFF);
        put_reg(8'h3F, 8'hEE);
        get_reg(8'h35, v); chk("R6 read index 0x15", v, 8'h00);
        get_reg(8'h1F, v); chk("R6 read index 0x1F", v, 8'h00);
        get_reg(8'h14, v); chk("R6 reg 0x14 untouched", v, 8'h00);
        get_reg(8'h00, v); chk("R6 reg 0x00 untouched", v, 8'h00);
    endtask

    task automatic t_csel;
        logic [7:0] v;
        put_reg(8'h34, 8'hFF);
        get_reg(8'h34, v); chk("R7 colour select low nibble", v, 8'h0F);
        put_reg(8'h14, 8'hA6);
        get_reg(8'h14, v); chk("R7 colour select 0xA6", v, 8'h06);
    endtask

    task automatic t_mode;
        logic [7:0] v;
        put_reg(8'h30, 8'h80);
        get_reg(8'h30, v); chk("R8 mode paging bit", v, 8'h80);
        put_reg(8'h30, v | 8'h08);
        get_reg(8'h30, v); chk("R8 mode set intensity", v, 8'h88);
        put_reg(8'h30, v & 8'hF7);
        get_reg(8'h30, v); chk("R8 mode clear intensity", v, 8'h80);
        put_reg(8'h31, 8'hC3);
        get_reg(8'h31, v); chk("R8 overscan full byte", v, 8'hC3);
        put_reg(8'h13, 8'h5A);
        get_reg(8'h13, v); chk("R8 reg 0x13 full byte", v, 8'h5A);
    endtask

    task automatic t_overlap;
        logic [7:0] v;
        rd_status(v);
        wr(8'h21);
        @(negedge clk);
        bus_rd_status = 1'b1; bus_wr = 1'b1; bus_wdata = 8'h22;
        @(negedge clk);
        bus_rd_status = 1'b0; bus_wr = 1'b0;
        rd_index(v);  chk("R10 overlap write is index", v, 8'h22);
        rd_status(v); chk("R10 overlap ends in data phase", v, 8'h01);
    endtask

    task automatic t_read_mux;
        logic [7:0] v;
        rd_status(v);
        wr(8'h22);
        @(negedge clk); #2;
        chk("R12 idle read zero", bus_rdata, 8'h00);
        bus_rd_data = 1'b1; bus_rd_index = 1'b1; #2;
        chk("R12 data over index", bus_rdata, 8'h33);
        bus_rd_status = 1'b1; #2;
        chk("R12 status over data", bus_rdata, 8'h01);
        @(negedge clk);
        bus_rd_data = 1'b0; bus_rd_index = 1'b0; bus_rd_status = 1'b0;
    endtask

    task automatic t_reset_again;
        logic [7:0] v;
        rd_status(v);
        wr(8'h21);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R1 screen off after second reset", {7'b0, screen_on}, 8'h00);
        rd_status(v); chk("R1 phase after second reset", v, 8'h00);
        get_reg(8'h01, v); chk("R1 reg1 cleared", v, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_index_data();
        t_alternate();
        t_status_mid();
        t_data_read_no_toggle();
        t_out_of_range();
        t_csel();
        t_mode();
        t_overlap();
        t_read_mux();
        t_reset_again();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule